// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block sequences the low-power modes of a small 8-bit processor core. Software writes a power control register that holds an idle-select bit, a stop-select bit and general-purpose flag bits. When the instruction that wrote a select bit retires, the block moves into the chosen mode. It drives three enables, one each for the CPU clock, the peripheral clocks and the internal oscillator. It also reports the current mode as a 2-bit code.

Idle and stop have different exit rules. In idle only the CPU clock is gated. Any enabled interrupt brings the core back, clears the idle-select bit and flags the wake with a one-cycle pulse. In stop everything is halted, and only a reset ends the mode: the external reset, a watchdog request or an internal reset from the missing-clock detector. Any reset puts the core back through its reset sequence, so it restarts at address 0x0000. A separate oscillator suspend state is left on USB activity or when the VBUS level matches a configured polarity.

The missing-clock detector runs on a free-running low-frequency reference clock. It checks the system clock with a toggle handshake. If the system clock stays silent for a set number of reference periods, it raises an internal reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_rst` is 1, `pm_state` is 00, `reg_rdata` is 0 and all three enables are 1. `core_rst` falls within SYNC_STAGES+1 clock edges after `rst_n` rises.
- R2: In the run state, `reg_we` stores `reg_wdata` into the power register, which shows on `reg_rdata` after the next clock edge. Bit 0 is idle-select, bit 1 is stop-select, and the upper bits are plain flags.
- R3: A select bit takes effect only on an edge where `instr_done` is 1. The bit may have been written earlier or in that same cycle. Without `instr_done` the state stays run (00).
- R4: In idle, `pm_state` is 01, `cpu_clk_en` is 0, and `per_clk_en` and `osc_en` are 1.
- R5: In stop, `pm_state` is 10 and all three enables are 0. If both select bits are 1 when `instr_done` arrives, stop is chosen.
- R6: In idle, any bit set in both `irq_req` and `irq_en` returns the state to run at the next edge. It clears register bit 0, keeps the other bits and pulses `irq_wake` for one cycle. A masked request has no effect.
- R7: In stop, interrupts do not change the state, whatever the enable mask.
- R8: `wdt_req` in any state makes the next edge return to run with the register cleared, and `core_rst` is 1 for that cycle.
- R9: In run, `susp_req` enters suspend (11) with the CPU and peripheral enables at 0. `osc_en` then follows `usb_evt` OR (`vbus` == `vbus_pol`) combinationally. That same condition returns the state to run at the next edge.
- R10: With `mcd_en` at 1 and no suspend, a system clock that stays silent for MCD_LIMIT reference periods raises an internal reset. `core_rst` goes to 1, the state goes to run, the enables go to 1 and the register clears, all without a system clock edge. The reset is released once the clock returns. A running clock never fires it.
- R11: Register writes outside the run state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from the internal oscillator |
| ref_clk | input | 1 | Free-running low-frequency reference for the missing-clock detector |
| rst_n | input | 1 | External reset, active low, asynchronous |
| reg_we | input | 1 | Power register write strobe |
| reg_wdata | input | REG_W | Power register write data |
| instr_done | input | 1 | Retirement strobe of the current instruction |
| irq_req | input | N_IRQ | Pending interrupt lines |
| irq_en | input | N_IRQ | Interrupt enable mask |
| wdt_req | input | 1 | Watchdog reset request, synchronous |
| susp_req | input | 1 | Request to suspend the internal oscillator |
| usb_evt | input | 1 | Non-idle USB bus activity |
| vbus | input | 1 | VBUS sense level |
| vbus_pol | input | 1 | VBUS level that wakes from suspend |
| mcd_en | input | 1 | Missing-clock detector enable |
| reg_rdata | output | REG_W | Power register contents |
| pm_state | output | 2 | Mode code: 00 run, 01 idle, 10 stop, 11 suspend |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Internal oscillator enable |
| core_rst | output | 1 | Reset to the core (restart at address 0x0000) |
| irq_wake | output | 1 | One-cycle pulse when an interrupt ends idle |

## Verification
The state code, the register, `irq_wake` and the watchdog-driven `core_rst` are all registered. Each is due one clock edge after the inputs that cause it, so the bench changes inputs one time unit after a rising edge and compares right after the following edge. `osc_en` in suspend is combinational, so it is checked before any edge, while the wake inputs are held. The external reset release takes SYNC_STAGES edges, and the missing-clock reset depends only on reference periods. Those checks wait fixed multiples of the reference period, with margins above MCD_LIMIT and the handshake round trip.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_IDLE = 2'b01,
      PM_STOP = 2'b10,
      PM_SUSP = 2'b11
   } pm_state_e;

   // positions decoded by the sequencer
   localparam int unsigned IDLE_BIT = 0;
   localparam int unsigned STOP_BIT = 1;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pmc_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ok,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             clr_all,
   input  logic             clr_idle,
   output logic [REG_W-1:0] q,
   output logic [1:0]       sel_next
);

   logic [REG_W-1:0] q_nxt;

   always_comb begin
      if (clr_all) begin
         q_nxt = '0;
      end else if (we && wr_ok) begin
         q_nxt = wdata;
      end else begin
         q_nxt = q;
      end
      if (clr_idle && !clr_all) begin
         q_nxt[IDLE_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   assign sel_next = {q_nxt[STOP_BIT], q_nxt[IDLE_BIT]};

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wdt_req,
   input  logic      instr_done,
   input  logic [1:0] sel_next,
   input  logic      susp_req,
   input  logic      irq_hit,
   input  logic      wake_susp,
   output pm_state_e st,
   output logic      irq_wake,
   output logic      clr_idle
);

   assign clr_idle = (st == PM_IDLE) && irq_hit && !wdt_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= PM_RUN;
         irq_wake <= 1'b0;
      end else begin
         irq_wake <= 1'b0;
         if (wdt_req) begin
            st <= PM_RUN;
         end else begin
            case (st)
               PM_RUN: begin
                  if (instr_done && sel_next[1])      st <= PM_STOP;
                  else if (instr_done && sel_next[0]) st <= PM_IDLE;
                  else if (susp_req)                  st <= PM_SUSP;
               end
               PM_IDLE: begin
                  if (irq_hit) begin
                     st       <= PM_RUN;
                     irq_wake <= 1'b1;
                  end
               end
               PM_SUSP: begin
                  if (wake_susp) st <= PM_RUN;
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   entry_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == PM_IDLE || st == PM_STOP) && $past(st) == PM_RUN) |-> $past(instr_done));

   // R7
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_STOP && !wdt_req) |=> (st == PM_STOP));

   // R6
   idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PM_IDLE && irq_hit && !wdt_req) |=> (st == PM_RUN && irq_wake));

   // R6
   wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wake |-> (st == PM_RUN && $past(st) == PM_IDLE));

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
   import pmc_pkg::*;
(
   input  pm_state_e st,
   input  logic      wake_susp,
   output logic      cpu_clk_en,
   output logic      per_clk_en,
   output logic      osc_en
);

   always_comb begin
      cpu_clk_en = 1'b0;
      per_clk_en = 1'b0;
      osc_en     = 1'b0;
      case (st)
         PM_RUN: begin
            cpu_clk_en = 1'b1;
            per_clk_en = 1'b1;
            osc_en     = 1'b1;
         end
         PM_IDLE: begin
            per_clk_en = 1'b1;
            osc_en     = 1'b1;
         end
         PM_SUSP: osc_en = wake_susp;
         default: ;
      endcase
   end

endmodule

// File: rtl/pmc_clk_mon.sv
module pmc_clk_mon #(
   parameter int unsigned LIMIT = 16,
   parameter int unsigned SYNC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_clk,
   input  logic mon_en,
   input  logic susp,
   output logic fire
);

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

   if (LIMIT <= 2 * SYNC + 2) begin : g_bad_limit
      $error("missing-clock limit must exceed the handshake round trip");
   end

   logic          req_q;
   logic          ack_c;
   logic          ack_r;
   logic          en_r;
   logic          susp_r;
   logic          armed;
   logic          alive;
   logic [CW-1:0] cnt;

   // echo of the request, clocked by the monitored clock
   pmc_sync #(.W(1), .STAGES(SYNC)) u_echo (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_q),
      .q     (ack_c)
   );

   pmc_sync #(.W(3), .STAGES(SYNC)) u_back (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     ({ack_c, mon_en, susp}),
      .q     ({ack_r, en_r, susp_r})
   );

   assign armed = en_r && !susp_r;
   assign alive = (ack_r == req_q);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         cnt   <= '0;
         fire  <= 1'b0;
      end else begin
         if (alive) req_q <= ~req_q;
         if (!armed || alive)  cnt <= '0;
         else if (cnt != LIM_C) cnt <= cnt + 1'b1;
         fire <= armed && !alive && (cnt == LIM_C);
      end
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned REG_W       = 8,
   parameter int unsigned N_IRQ       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MCD_LIMIT   = 16,
   parameter bit          MCD_EN      = 1'b1
) (
   input  logic             clk,
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             instr_done,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             wdt_req,
   input  logic             susp_req,
   input  logic             usb_evt,
   input  logic             vbus,
   input  logic             vbus_pol,
   input  logic             mcd_en,
   output logic [REG_W-1:0] reg_rdata,
   output logic [1:0]       pm_state,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             core_rst,
   output logic             irq_wake
);

   if (REG_W < 2) begin : g_bad_reg_w
      $error("power register needs both select bits");
   end
   if (N_IRQ < 1) begin : g_bad_n_irq
      $error("at least one interrupt line is required");
   end

   pm_state_e  st;
   logic       mcd_fire;
   logic       rst_raw_n;
   logic       sys_rst_n;
   logic       irq_hit;
   logic       wake_susp;
   logic       clr_idle;
   logic [1:0] sel_next;
   logic       wdt_q;

   assign rst_raw_n = rst_n && !mcd_fire;
   assign irq_hit   = |(irq_req & irq_en);
   assign wake_susp = usb_evt || (vbus == vbus_pol);

   pmc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
      .clk   (clk),
      .rst_n (rst_raw_n),
      .d     (1'b1),
      .q     (sys_rst_n)
   );

   if (MCD_EN) begin : g_mcd
      pmc_clk_mon #(.LIMIT(MCD_LIMIT), .SYNC(SYNC_STAGES)) u_mon (
         .clk     (clk),
         .rst_n   (rst_n),
         .ref_clk (ref_clk),
         .mon_en  (mcd_en),
         .susp    (st == PM_SUSP),
         .fire    (mcd_fire)
      );
   end else begin : g_no_mcd
      assign mcd_fire = 1'b0;
   end

   pmc_ctrl_reg #(.REG_W(REG_W)) u_reg (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .wr_ok    (st == PM_RUN),
      .we       (reg_we),
      .wdata    (reg_wdata),
      .clr_all  (wdt_req),
      .clr_idle (clr_idle),
      .q        (reg_rdata),
      .sel_next (sel_next)
   );

   pmc_fsm u_fsm (
      .clk        (clk),
      .rst_n      (sys_rst_n),
      .wdt_req    (wdt_req),
      .instr_done (instr_done),
      .sel_next   (sel_next),
      .susp_req   (susp_req),
      .irq_hit    (irq_hit),
      .wake_susp  (wake_susp),
      .st         (st),
      .irq_wake   (irq_wake),
      .clr_idle   (clr_idle)
   );

   pmc_clk_gate u_gate (
      .st         (st),
      .wake_susp  (wake_susp),
      .cpu_clk_en (cpu_clk_en),
      .per_clk_en (per_clk_en),
      .osc_en     (osc_en)
   );

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) wdt_q <= 1'b0;
      else            wdt_q <= wdt_req;
   end

   assign core_rst = !sys_rst_n || wdt_q;
   assign pm_state = st;

   // R11
   write_ignored_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (st != PM_RUN && !wdt_req && !clr_idle) |=> $stable(reg_rdata));

   // R8
   wdt_return_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      wdt_req |=> (st == PM_RUN && reg_rdata == '0 && core_rst));

endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

   localparam int REG_W = 8;
   localparam int N_IRQ = 4;
   localparam int REF_HALF = 80;

   logic clk = 1'b0;
   logic ref_clk = 1'b0;
   logic clk_hold = 1'b0;
   logic rst_n;
   logic reg_we, instr_done, wdt_req, susp_req, usb_evt, vbus, vbus_pol, mcd_en;
   logic [REG_W-1:0] reg_wdata;
   logic [N_IRQ-1:0] irq_req, irq_en;
   logic [REG_W-1:0] reg_rdata;
   logic [1:0] pm_state;
   logic cpu_clk_en, per_clk_en, osc_en, core_rst, irq_wake;

   int n_chk = 0;
   int n_err = 0;

   logic [1:0]       m_st;
   logic [REG_W-1:0] m_reg;
   logic             m_wake;
   logic             m_crst;

   always #10 if (!clk_hold) clk = ~clk;
   always #(REF_HALF) ref_clk = ~ref_clk;

   pwr_mode_ctrl uut (
      .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .instr_done(instr_done),
      .irq_req(irq_req), .irq_en(irq_en), .wdt_req(wdt_req),
      .susp_req(susp_req), .usb_evt(usb_evt), .vbus(vbus),
      .vbus_pol(vbus_pol), .mcd_en(mcd_en), .reg_rdata(reg_rdata),
      .pm_state(pm_state), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .core_rst(core_rst),
      .irq_wake(irq_wake)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_en(input logic [1:0] s);
      // {cpu, per, osc}
      case (s)
         2'b00:   return 3'b111;
         2'b01:   return 3'b011;
         2'b10:   return 3'b000;
         default: return {2'b00, usb_evt | (vbus == vbus_pol)};
      endcase
   endfunction

   task automatic clear_inputs();
      reg_we = 0; reg_wdata = '0; instr_done = 0; irq_req = '0; irq_en = '0;
      wdt_req = 0; susp_req = 0; usb_evt = 0; vbus = 0; vbus_pol = 1;
   endtask

   task automatic model_step();
      logic [REG_W-1:0] nreg;
      m_wake = 0;
      m_crst = wdt_req;
      if (wdt_req) begin
         m_st = 2'b00; m_reg = '0;
      end else begin
         case (m_st)
            2'b00: begin
               nreg = reg_we ? reg_wdata : m_reg;
               if (instr_done && nreg[1])      m_st = 2'b10;
               else if (instr_done && nreg[0]) m_st = 2'b01;
               else if (susp_req)              m_st = 2'b11;
               m_reg = nreg;
            end
            2'b01: if (|(irq_req & irq_en)) begin
               m_st = 2'b00; m_reg[0] = 1'b0; m_wake = 1;
            end
            2'b11: if (usb_evt || (vbus == vbus_pol)) m_st = 2'b00;
            default: ;
         endcase
      end
   endtask

   task automatic check_all(input string req);
      logic [2:0] e;
      e = exp_en(m_st);
      check(req, "pm_state", 32'(pm_state), 32'(m_st));
      check(req, "reg_rdata", 32'(reg_rdata), 32'(m_reg));
      check(req, "cpu_clk_en", 32'(cpu_clk_en), 32'(e[2]));
      check(req, "per_clk_en", 32'(per_clk_en), 32'(e[1]));
      check(req, "osc_en", 32'(osc_en), 32'(e[0]));
      check(req, "irq_wake", 32'(irq_wake), 32'(m_wake));
      check(req, "core_rst", 32'(core_rst), 32'(m_crst));
   endtask

   // inputs already set; advance one edge and compare
   task automatic step(input string req);
      model_step();
      @(posedge clk); #1;
      check_all(req);
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      clear_inputs(); mcd_en = 0; rst_n = 0;
      repeat (3) @(posedge clk); #1;
      // R1 values held during reset
      check("R1", "core_rst", 32'(core_rst), 1);
      check("R1", "pm_state", 32'(pm_state), 0);
      check("R1", "reg_rdata", 32'(reg_rdata), 0);
      check("R1", "enables", 32'({cpu_clk_en, per_clk_en, osc_en}), 32'h7);
      rst_n = 1;
      repeat (3) @(posedge clk); #1;
      check("R1", "core_rst released", 32'(core_rst), 0);
      m_st = 0; m_reg = '0; m_wake = 0; m_crst = 0;

      // R2 plain write, no select bits
      reg_we = 1; reg_wdata = 8'hA4; step("R2");
      clear_inputs();
      // R3 idle bit without retirement strobe
      reg_we = 1; reg_wdata = 8'hF1; step("R3");
      clear_inputs(); step("R3"); step("R3");
      // R3 / R4 retirement enters idle
      instr_done = 1; step("R4");
      clear_inputs();
      // R11 write in idle ignored
      reg_we = 1; reg_wdata = 8'h00; instr_done = 1; step("R11");
      clear_inputs();
      // R6 masked request does nothing
      irq_req = 4'b0001; irq_en = 4'b1110; step("R6");
      // R6 enabled request wakes, bit 0 cleared (F0 expected)
      irq_req = 4'b0100; irq_en = 4'b0100; step("R6");
      check("R6", "reg after wake", 32'(reg_rdata), 32'hF0);
      clear_inputs(); step("R6");
      // R5 both bits with strobe in same cycle: stop wins
      reg_we = 1; reg_wdata = 8'h03; instr_done = 1; step("R5");
      clear_inputs();
      // R7 interrupts cannot end stop; R11 write ignored
      irq_req = '1; irq_en = '1; reg_we = 1; reg_wdata = 8'h55; step("R7");
      step("R7");
      clear_inputs();
      // R8 watchdog ends stop
      wdt_req = 1; step("R8");
      clear_inputs(); step("R8");
      // R9 suspend, vbus wake path
      susp_req = 1; vbus = 0; vbus_pol = 1; step("R9");
      susp_req = 0; step("R9");
      vbus = 1; #1;
      check("R9", "osc_en comb", 32'(osc_en), 1);
      step("R9");
      clear_inputs();
      // R9 usb wake path
      susp_req = 1; vbus = 1; vbus_pol = 0; step("R9");
      susp_req = 0; step("R9");
      usb_evt = 1; #1;
      check("R9", "osc_en usb", 32'(osc_en), 1);
      step("R9");
      clear_inputs();
      // R8 watchdog ends idle
      reg_we = 1; reg_wdata = 8'h01; instr_done = 1; step("R8");
      clear_inputs(); wdt_req = 1; step("R8");
      clear_inputs(); step("R8");

      // random mix, all requirements R2..R9, R11
      for (int i = 0; i < 2000; i++) begin
         reg_we     = ($urandom_range(0, 3) == 0);
         reg_wdata  = REG_W'($urandom());
         instr_done = ($urandom_range(0, 3) == 0);
         irq_req    = N_IRQ'($urandom());
         irq_en     = N_IRQ'($urandom());
         wdt_req    = ($urandom_range(0, 63) == 0);
         susp_req   = ($urandom_range(0, 15) == 0);
         usb_evt    = ($urandom_range(0, 7) == 0);
         vbus       = 1'($urandom());
         vbus_pol   = 1'($urandom());
         step("R2 random");
      end
      clear_inputs(); wdt_req = 1; step("R8");
      clear_inputs(); step("R8");

      // R10 running clock never fires the detector
      mcd_en = 1;
      for (int i = 0; i < 500; i++) step("R10 no false fire");
      // R10 enter stop, then silence the clock
      reg_we = 1; reg_wdata = 8'h02; instr_done = 1; step("R10");
      clear_inputs();
      clk_hold = 1;
      #(2 * REF_HALF * 40);
      check("R10", "core_rst", 32'(core_rst), 1);
      check("R10", "pm_state", 32'(pm_state), 0);
      check("R10", "osc_en", 32'(osc_en), 1);
      check("R10", "reg_rdata", 32'(reg_rdata), 0);
      clk_hold = 0;
      #(2 * REF_HALF * 30);
      @(posedge clk); #1;
      m_st = 0; m_reg = '0; m_wake = 0; m_crst = 0;
      check_all("R10 release");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule